// File: doc/BRIEF.md
# Adaptive Digital Gain Control Loop

This block scales a stream of signed 16-bit samples by a gain coefficient that it adjusts itself. Each valid sample is multiplied by an unsigned Q2.14 coefficient, shifted back into 16-bit range and clipped, then presented one cycle later. In the same cycle the block works out whether the scaled sample is too loud or too quiet and moves the coefficient one step the other way, using only the sign of the error (sign-error LMS).

The error can come from one of two places. In level mode the block compares the magnitude of its own output with a programmable 16-bit target. In equalizer mode it takes an error value from a downstream decision stage, supplied in the same cycle as the input sample it refers to. Software can freeze the loop, which keeps the coefficient unchanged, and can switch to a coarse step eight times the fine one for fast acquisition.

Top module: `agc_gain_loop`

## Requirements
- R1: After reset the coefficient `gain_coef` reads 0x4000 (unity gain in Q2.14), `out_valid` is 0 and `out_sample` is 0.
- R2: For a sample taken with `in_valid` high, `out_sample` on the next cycle equals floor(`in_sample` × `gain_coef` / 2^14), using the coefficient held before that edge, and `out_valid` is high exactly in the cycle after each cycle with `in_valid` high.
- R3: A scaled result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R4: With `err_src_ext` = 0, the error is |scaled sample| minus `target_lvl`: a positive error lowers the coefficient by one step, a negative error raises it by one step, and a zero error leaves it unchanged. `eq_err` has no effect in this mode.
- R5: With `err_src_ext` = 1, the error is `eq_err`, read in the same cycle as its sample. If `eq_err` and the scaled sample have the same sign the coefficient drops one step, if the signs differ it rises one step, and if either is zero it stays. `target_lvl` has no effect in this mode.
- R6: With `adapt_en` = 0 the coefficient holds its value whatever the error, while samples are still scaled.
- R7: The step is 1 LSB with `step_big` = 0 and 8 LSB with `step_big` = 1.
- R8: The coefficient clamps at 0 and at 0xFFFF instead of wrapping around.
- R9: In a cycle with `in_valid` low the coefficient does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 16 | Signed input sample |
| err_src_ext | input | 1 | 1 = equalizer error, 0 = level-versus-target error |
| adapt_en | input | 1 | 1 = coefficient adapts, 0 = frozen |
| step_big | input | 1 | 1 = 8-LSB step, 0 = 1-LSB step |
| target_lvl | input | 16 | Unsigned target magnitude for level mode |
| eq_err | input | 16 | Signed equalizer error aligned with `in_sample` |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | 16 | Signed scaled and clipped sample |
| gain_coef | output | 16 | Current unsigned Q2.14 gain coefficient |

## Verification
The bench drives the coefficient all the way up to 0xFFFF and down to 0 with the coarse step; since neither end is a multiple of 8 away from the start, the last step of each run must clamp, and a design that wraps would jump to a tiny or huge gain and the cycle-by-cycle model comparison would diverge at once. At full gain it feeds full-scale positive and negative samples, where a missing clip would flip the sign of the output. It hits the exact tie between magnitude and target, where a design using >= instead of > would creep the gain, and the equalizer-mode sign cases with negative outputs, where a design that ignored the output sign would drive the gain the wrong way.

// File: rtl/agc_gain_loop.sv
module agc_gain_loop #(
  parameter int W         = 16,
  parameter int CW        = 16,
  parameter int FRAC      = 14,
  parameter int BIG_SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_sample,
  input  logic          err_src_ext,
  input  logic          adapt_en,
  input  logic          step_big,
  input  logic [W-1:0]  target_lvl,
  input  logic [W-1:0]  eq_err,
  output logic          out_valid,
  output logic [W-1:0]  out_sample,
  output logic [CW-1:0] gain_coef
);

  localparam int PW = W + CW + 1;
  localparam logic signed [PW-1:0] Y_MAX = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] Y_MIN = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic [CW:0] C_MAX    = {1'b0, {CW{1'b1}}};
  localparam logic [CW:0] STEP_LO  = (CW+1)'(1);
  localparam logic [CW:0] STEP_HI  = STEP_LO << BIG_SHIFT;
  localparam logic [CW-1:0] C_UNITY = CW'(1) << FRAC;

  // scaling
  logic signed [PW-1:0] prod, scaled;
  logic [W-1:0] y_sat;

  assign prod   = $signed(in_sample) * $signed({1'b0, gain_coef});
  assign scaled = prod >>> FRAC;
  assign y_sat  = (scaled > Y_MAX) ? Y_MAX[W-1:0] :
                  (scaled < Y_MIN) ? Y_MIN[W-1:0] : scaled[W-1:0];

  // error sign
  logic [W:0] y_ext, y_mag;
  logic y_neg, y_zero, e_neg, e_zero;
  logic go_down, go_up;

  assign y_ext  = {y_sat[W-1], y_sat};
  assign y_mag  = y_ext[W] ? (~y_ext + 1'b1) : y_ext;
  assign y_neg  = y_sat[W-1];
  assign y_zero = (y_sat == '0);
  assign e_neg  = eq_err[W-1];
  assign e_zero = (eq_err == '0);

  always_comb begin
    if (err_src_ext) begin
      go_down = !e_zero && !y_zero && (e_neg == y_neg);
      go_up   = !e_zero && !y_zero && (e_neg != y_neg);
    end else begin
      go_down = y_mag > {1'b0, target_lvl};
      go_up   = y_mag < {1'b0, target_lvl};
    end
  end

  // coefficient update
  logic [CW:0] step, c_ext, c_sum;
  logic [CW-1:0] c_next;

  assign step  = step_big ? STEP_HI : STEP_LO;
  assign c_ext = {1'b0, gain_coef};
  assign c_sum = c_ext + step;

  always_comb begin
    c_next = gain_coef;
    if (go_down)
      c_next = (c_ext < step) ? '0 : CW'(c_ext - step);
    else if (go_up)
      c_next = (c_sum > C_MAX) ? C_MAX[CW-1:0] : c_sum[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_coef  <= C_UNITY;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sample <= y_sat;
        if (adapt_en) gain_coef <= c_next;
      end
    end
  end

  // checks
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_frozen_coef_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !adapt_en) |=> $stable(gain_coef));
  assert_idle_coef_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(gain_coef));
  assert_fine_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && adapt_en && !step_big) |=>
      (gain_coef == $past(gain_coef) ||
       gain_coef == $past(gain_coef) + CW'(1) ||
       gain_coef == $past(gain_coef) - CW'(1)));
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && adapt_en) |=>
      ((gain_coef >= $past(gain_coef)) ? (gain_coef - $past(gain_coef))
                                       : ($past(gain_coef) - gain_coef)) <= STEP_HI[CW-1:0]);
  assert_ext_ignores_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && adapt_en && err_src_ext && e_zero) |=> $stable(gain_coef));

endmodule

// File: tb/test_agc_gain_loop.sv
`timescale 1ns/1ps
module test_agc_gain_loop;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic err_src_ext = 1'b0;
  logic adapt_en = 1'b0;
  logic step_big = 1'b0;
  logic [15:0] target_lvl = '0;
  logic [15:0] eq_err = '0;
  logic out_valid;
  logic [15:0] out_sample;
  logic [15:0] gain_coef;

  int n_run = 0;
  int n_fail = 0;
  int bad = 0;
  logic [15:0] exp_coef;

  always #2.5 clk = ~clk;

  agc_gain_loop i_agc_gain_loop (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .err_src_ext(err_src_ext), .adapt_en(adapt_en), .step_big(step_big),
    .target_lvl(target_lvl), .eq_err(eq_err), .out_valid(out_valid),
    .out_sample(out_sample), .gain_coef(gain_coef)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_y(input logic [15:0] x, input logic [15:0] c);
    longint p;
    p = longint'($signed(x)) * longint'({16'h0, c});
    p = p >>> 14;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  function automatic logic [15:0] model_coef(input int y, input logic [15:0] c,
      input bit ext, input bit en, input bit big, input logic [15:0] tgt, input logic [15:0] e);
    int mag, es, dir, st, nc;
    if (!en) return c;
    mag = (y < 0) ? -y : y;
    es  = $signed(e);
    if (ext) dir = (es == 0 || y == 0) ? 0 : (((es < 0) == (y < 0)) ? -1 : 1);
    else     dir = (mag > int'(tgt)) ? -1 : ((mag < int'(tgt)) ? 1 : 0);
    st = big ? 8 : 1;
    nc = int'(c) + dir * st;
    if (nc < 0) nc = 0;
    if (nc > 65535) nc = 65535;
    return 16'(nc);
  endfunction

  // one valid sample; compares output and coefficient with the model, counts mismatches in bad
  task automatic sample(input logic [15:0] x, input bit ext, input bit en, input bit big,
                        input logic [15:0] tgt, input logic [15:0] e);
    int ey;
    @(negedge clk);
    in_valid = 1'b1; in_sample = x; err_src_ext = ext; adapt_en = en;
    step_big = big; target_lvl = tgt; eq_err = e;
    ey = model_y(x, exp_coef);
    exp_coef = model_coef(ey, exp_coef, ext, en, big, tgt, e);
    @(negedge clk);
    in_valid = 1'b0;
    if (!out_valid || $signed(out_sample) != ey || gain_coef != exp_coef) bad++;
  endtask

  task automatic t_reset();
    check(gain_coef == 16'h4000, "R1 coef", gain_coef, 16'h4000);
    check(out_valid == 1'b0, "R1 valid", out_valid, 0);
    check(out_sample == 16'h0, "R1 out", out_sample, 0);
  endtask

  task automatic t_scale();
    bad = 0;
    sample(16'd1000, 0, 0, 0, 0, 0);
    check($signed(out_sample) == 1000, "R2 unity", $signed(out_sample), 1000);
    sample(-16'sd1234, 0, 0, 0, 0, 0);
    check($signed(out_sample) == -1234, "R2 negative", $signed(out_sample), -1234);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 valid one cycle", out_valid, 0);
    check(bad == 0, "R2 model", bad, 0);
  endtask

  task automatic t_self();
    bad = 0;
    sample(16'd1000, 0, 1, 0, 16'd2000, 16'h7fff);
    check(gain_coef == 16'h4001, "R4 quiet raises", gain_coef, 16'h4001);
    sample(16'd1000, 0, 1, 1, 16'd2000, 0);
    check(gain_coef == 16'h4009, "R7 big step", gain_coef, 16'h4009);
    sample(16'd1000, 0, 1, 0, 16'd500, 0);
    check(gain_coef == 16'h4008, "R4 loud lowers", gain_coef, 16'h4008);
    sample(16'd1000, 0, 1, 1, 16'd1000, 16'h8000);
    check(gain_coef == 16'h4008, "R4 tie holds", gain_coef, 16'h4008);
    check(bad == 0, "R4 model", bad, 0);
  endtask

  task automatic t_ext();
    bad = 0;
    sample(16'd1000, 1, 1, 0, 16'd0, 16'd5);
    check(gain_coef == 16'h4007, "R5 same sign lowers", gain_coef, 16'h4007);
    sample(-16'sd1000, 1, 1, 0, 16'd0, 16'd5);
    check(gain_coef == 16'h4008, "R5 opposite sign raises", gain_coef, 16'h4008);
    sample(-16'sd1000, 1, 1, 1, 16'd0, -16'sd3);
    check(gain_coef == 16'h4000, "R5 both negative lowers", gain_coef, 16'h4000);
    sample(16'd1000, 1, 1, 1, 16'd0, 16'd0);
    check(gain_coef == 16'h4000, "R5 zero error holds", gain_coef, 16'h4000);
    sample(16'd0, 1, 1, 1, 16'd9000, 16'd7);
    check(gain_coef == 16'h4000, "R5 zero output holds", gain_coef, 16'h4000);
    check(bad == 0, "R5 model", bad, 0);
  endtask

  task automatic t_freeze();
    bad = 0;
    sample(16'd1000, 0, 0, 1, 16'd30000, 0);
    sample(16'd1000, 1, 0, 1, 0, 16'd100);
    check(gain_coef == 16'h4000, "R6 frozen", gain_coef, 16'h4000);
    check(bad == 0, "R6 model", bad, 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    in_valid = 1'b0; adapt_en = 1'b1; step_big = 1'b1; err_src_ext = 1'b0;
    in_sample = 16'd1000; target_lvl = 16'd30000;
    repeat (4) @(negedge clk);
    check(gain_coef == 16'h4000, "R9 idle holds", gain_coef, 16'h4000);
    check(out_valid == 1'b0, "R9 no output", out_valid, 0);
  endtask

  task automatic t_limits();
    bad = 0;
    for (int i = 0; i < 6200; i++) sample(16'd0, 0, 1, 1, 16'd100, 0);
    check(gain_coef == 16'hffff, "R8 top clamp", gain_coef, 16'hffff);
    sample(16'h7fff, 0, 0, 0, 0, 0);
    check(out_sample == 16'h7fff, "R3 positive clip", out_sample, 16'h7fff);
    sample(16'h8000, 0, 0, 0, 0, 0);
    check(out_sample == 16'h8000, "R3 negative clip", out_sample, 16'h8000);
    sample(-16'sd10000, 0, 0, 0, 0, 0);
    check(out_sample == 16'h8000, "R3 negative clip mid", out_sample, 16'h8000);
    for (int i = 0; i < 8300; i++) sample(16'h7fff, 0, 1, 1, 16'd0, 0);
    check(gain_coef == 16'h0000, "R8 bottom clamp", gain_coef, 0);
    check(out_sample == 16'h0000, "R2 zero gain", out_sample, 0);
    check(bad == 0, "R8 model", bad, 0);
  endtask

  initial begin
    #(150000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    exp_coef = 16'h4000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scale();
    t_self();
    exp_coef = gain_coef == 16'h4008 ? 16'h4008 : exp_coef;
    t_ext();
    t_freeze();
    t_idle();
    t_limits();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule